// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block is the control path of a register-rename pipeline stage. Each cycle decode offers a group of up to `W` instruction slots. The group carries a slot count and, per slot, a squashed flag, a serializing flag, a destination-register count and an opaque tag. The controller decides how many of those slots go on to the issue stage this cycle. It presents their tags packed from output position 0 upward, together with the number of physical registers the external rename map must allocate.

Three limits can stop renaming part-way through a group. The first is the free reorder-buffer and issue-queue entries reported downstream, each reduced by a reserve that covers the feedback delay. The second is the physical-register pool, and the third is a serializing instruction. When renaming stops, the stage stalls decode and parks the group in a skid FIFO with the slot offset it reached, so that a later cycle can resume from that slot. Groups that arrive while the stage is stalled queue behind it. A squash from commit discards all of this.

Top module: `rename_flow_ctrl`

## Requirements
- R1: After reset the state output is Idle (code 0), `dec_stall` is low and `iss_count` is 0. State codes: Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4, BarrierStall 5.
- R2: Usable credit is min(`rob_free`, `iq_free`) minus `W*FB_DELAY`. No more instructions issue in a cycle than the usable credit. If the usable credit is zero or negative while slots are available, nothing issues, `dec_stall` rises in that cycle and the next state is Blocked.
- R3: If the usable credit is positive but smaller than the number of non-squashed slots that can be renamed, exactly that many issue in slot order. `dec_stall` rises and the stage blocks. On resume it continues from the first slot that did not issue.
- R4: A squashed slot is skipped. It spends no credit, issues nothing and moves the slot offset forward.
- R5: A slot issues only if `map_free`, less the destinations already allocated this cycle, is at least its own destination count. Otherwise renaming stops there and the stage blocks. `map_alloc` is the sum of the destination counts of the slots that issued.
- R6: A serializing slot issues only when it is the first slot to issue in its cycle and `rob_free` equals `ROB_ENTRIES`. Otherwise renaming stops, the stage enters BarrierStall, and it leaves that state only when the resume condition of R8 holds and the reorder buffer is drained.
- R7: In Blocked, BarrierStall and Unblocking, every nonempty group from decode is appended to the skid FIFO. Groups are renamed in arrival order. While blocked nothing issues and `dec_stall` stays high.
- R8: Blocked moves to Unblocking only in a cycle with no stall from issue or commit, both reduced credits positive and `map_free` nonzero. Unblocking moves to Running when it finishes the last queued group.
- R9: `squash_req` empties the skid FIFO, clears the slot offset and moves the stage to Squashing, then to Idle. No leftover group or offset reaches later renaming.
- R10: A cycle that ends without blocking clears the saved offset, so the next group starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_size | input | CNT_W | Number of slots in the offered group (0 = none) |
| dec_squashed | input | W | Per-slot squashed flag |
| dec_serial | input | W | Per-slot serializing flag |
| dec_ndst | input | W*DST_W | Per-slot destination-register count |
| dec_tag | input | W*TAG_W | Per-slot instruction tag |
| rob_free | input | CRD_W | Reported free reorder-buffer entries |
| iq_free | input | CRD_W | Reported free issue-queue entries |
| iew_stall | input | 1 | Stall from the issue stage |
| cmt_stall | input | 1 | Stall from commit |
| squash_req | input | 1 | Squash request from commit |
| map_free | input | PREG_W | Free physical registers in the rename map |
| dec_stall | output | 1 | Stall toward decode |
| iss_count | output | CNT_W | Instructions issued this cycle |
| iss_valid | output | W | Valid mask of packed output positions |
| iss_tag | output | W*TAG_W | Tags of issued instructions, position 0 first |
| map_alloc | output | ALLOC_W | Physical registers consumed this cycle |
| stage_state | output | 3 | Current controller state code |

## Verification
Two functions meet in the same cycle when the stage resumes a partly renamed group from the skid FIFO. Resuming from the saved offset and writing a new arrival into the same FIFO happen together, because arrivals keep coming during Unblocking. Blocking when credit is short also coincides with saving the offset reached. The directed sequences build these cases with chosen credit values. Each case is judged by the first tag issued after the resume and by the count that issues, which show whether the offset was kept or cleared and whether the groups kept their order.

// File: rtl/rnf_pkg.sv
package rnf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCKED = 3'd2,
    ST_UNBLOCK = 3'd3,
    ST_SQUASH  = 3'd4,
    ST_BARRIER = 3'd5
  } rnf_state_e;
endpackage

// File: rtl/rnf_credit.sv
module rnf_credit #(
  parameter int W           = 4,
  parameter int FB_DELAY    = 1,
  parameter int ROB_ENTRIES = 16,
  parameter int CRD_W       = 5,
  parameter int PREG_W      = 6,
  parameter int SW          = 9
) (
  input  logic [CRD_W-1:0]     rob_free,
  input  logic [CRD_W-1:0]     iq_free,
  input  logic                 iew_stall,
  input  logic                 cmt_stall,
  input  logic [PREG_W-1:0]    map_free,
  output logic signed [SW-1:0] credit_min,
  output logic                 resume_ok,
  output logic                 rob_drained
);
  localparam logic signed [SW-1:0] RESERVE = SW'(W * FB_DELAY);
  localparam logic signed [SW-1:0] ZERO_S  = '0;

  logic signed [SW-1:0] rob_use;
  logic signed [SW-1:0] iq_use;

  always_comb begin
    rob_use     = $signed(SW'(rob_free)) - RESERVE;
    iq_use      = $signed(SW'(iq_free)) - RESERVE;
    credit_min  = (rob_use < iq_use) ? rob_use : iq_use;
    rob_drained = (rob_free == CRD_W'(ROB_ENTRIES));
    resume_ok   = !iew_stall && !cmt_stall && (rob_use > ZERO_S) &&
                  (iq_use > ZERO_S) && (map_free != '0);
  end
endmodule

// File: rtl/rnf_skid.sv
module rnf_skid #(
  parameter int DEPTH = 4,
  parameter int GW    = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         clr,
  input  logic [GW-1:0]                din,
  output logic [GW-1:0]                dout,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [GW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             full, push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    pop_ok  = pop && !empty;
    push_ok = push && (!full || pop_ok);
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

  // R7: a queued group must never be lost to a write into a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |-> 1'b0);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);
endmodule

// File: rtl/rnf_slot_walk.sv
module rnf_slot_walk #(
  parameter int W       = 4,
  parameter int CNT_W   = 3,
  parameter int DST_W   = 2,
  parameter int TAG_W   = 8,
  parameter int PREG_W  = 6,
  parameter int SW      = 9,
  parameter int ALLOC_W = 4
) (
  input  logic [CNT_W-1:0]     grp_size,
  input  logic [CNT_W-1:0]     start_off,
  input  logic [W-1:0]         sq,
  input  logic [W-1:0]         ser,
  input  logic [W*DST_W-1:0]   ndst,
  input  logic [W*TAG_W-1:0]   tag,
  input  logic signed [SW-1:0] credit,
  input  logic [PREG_W-1:0]    preg_free,
  input  logic                 drained,
  output logic [CNT_W-1:0]     n_issue,
  output logic [CNT_W-1:0]     n_step,
  output logic                 blk,
  output logic                 ser_blk,
  output logic [W-1:0]         iss_valid,
  output logic [W*TAG_W-1:0]   iss_tag,
  output logic [ALLOC_W-1:0]   alloc
);
  localparam logic signed [SW-1:0] ZERO_S = '0;
  localparam logic signed [SW-1:0] ONE_S  = SW'(1);

  logic                 stop;
  logic signed [SW-1:0] cred;
  logic [PREG_W-1:0]    left;
  logic [DST_W-1:0]     nd;

  always_comb begin
    n_issue   = '0;
    n_step    = '0;
    blk       = 1'b0;
    ser_blk   = 1'b0;
    iss_valid = '0;
    iss_tag   = '0;
    alloc     = '0;
    stop      = 1'b0;
    cred      = credit;
    left      = preg_free;
    nd        = '0;
    if ((grp_size > start_off) && (credit <= ZERO_S)) begin
      blk  = 1'b1;
      stop = 1'b1;
    end
    for (int i = 0; i < W; i++) begin
      nd = ndst[i*DST_W +: DST_W];
      if (!stop && (CNT_W'(i) >= start_off) && (CNT_W'(i) < grp_size)) begin
        if (sq[i]) begin
          n_step = n_step + CNT_W'(1);
        end else if (cred <= ZERO_S) begin
          blk  = 1'b1;
          stop = 1'b1;
        end else if (ser[i] && !((n_issue == '0) && drained)) begin
          blk     = 1'b1;
          ser_blk = 1'b1;
          stop    = 1'b1;
        end else if (PREG_W'(nd) > left) begin
          blk  = 1'b1;
          stop = 1'b1;
        end else begin
          iss_valid[int'(n_issue)]             = 1'b1;
          iss_tag[int'(n_issue)*TAG_W +: TAG_W] = tag[i*TAG_W +: TAG_W];
          n_issue = n_issue + CNT_W'(1);
          n_step  = n_step + CNT_W'(1);
          cred    = cred - ONE_S;
          left    = left - PREG_W'(nd);
          alloc   = alloc + ALLOC_W'(nd);
        end
      end
    end
  end
endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl
  import rnf_pkg::*;
#(
  parameter int W           = 4,
  parameter int DST_W       = 2,
  parameter int TAG_W       = 8,
  parameter int PREG_W      = 6,
  parameter int ROB_ENTRIES = 16,
  parameter int IQ_ENTRIES  = 16,
  parameter int FB_DELAY    = 1,
  parameter int SKID_DEPTH  = 4,
  localparam int CNT_W   = $clog2(W + 1),
  localparam int CRD_W   = $clog2(((ROB_ENTRIES > IQ_ENTRIES) ? ROB_ENTRIES : IQ_ENTRIES) + 1),
  localparam int ALLOC_W = $clog2(W * ((1 << DST_W) - 1) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     dec_size,
  input  logic [W-1:0]         dec_squashed,
  input  logic [W-1:0]         dec_serial,
  input  logic [W*DST_W-1:0]   dec_ndst,
  input  logic [W*TAG_W-1:0]   dec_tag,
  input  logic [CRD_W-1:0]     rob_free,
  input  logic [CRD_W-1:0]     iq_free,
  input  logic                 iew_stall,
  input  logic                 cmt_stall,
  input  logic                 squash_req,
  input  logic [PREG_W-1:0]    map_free,
  output logic                 dec_stall,
  output logic [CNT_W-1:0]     iss_count,
  output logic [W-1:0]         iss_valid,
  output logic [W*TAG_W-1:0]   iss_tag,
  output logic [ALLOC_W-1:0]   map_alloc,
  output logic [2:0]           stage_state
);
  localparam int SW     = CRD_W + $clog2(W * FB_DELAY + 1) + 1;
  localparam int O_SQ   = CNT_W;
  localparam int O_SER  = O_SQ + W;
  localparam int O_DST  = O_SER + W;
  localparam int O_TAG  = O_DST + W * DST_W;
  localparam int GRP_W  = O_TAG + W * TAG_W;
  localparam int SCNT_W = $clog2(SKID_DEPTH + 1);

  rnf_state_e state_q, state_d;
  logic [CNT_W-1:0] off_q, off_d;

  logic signed [SW-1:0] credit_min;
  logic resume_ok, rob_drained;

  logic [GRP_W-1:0]  in_grp, skid_head, src;
  logic              skid_empty, skid_push, skid_pop;
  logic [SCNT_W-1:0] skid_cnt;
  logic              from_skid, working, in_nonempty, stalled_state;
  logic [CNT_W-1:0]  walk_size, walk_off;
  logic [CNT_W-1:0]  n_issue, n_step;
  logic              walk_blk, walk_ser, blk_now;

  assign in_grp      = {dec_tag, dec_ndst, dec_serial, dec_squashed, dec_size};
  assign in_nonempty = (dec_size != '0);

  rnf_credit #(
    .W(W), .FB_DELAY(FB_DELAY), .ROB_ENTRIES(ROB_ENTRIES),
    .CRD_W(CRD_W), .PREG_W(PREG_W), .SW(SW)
  ) u_credit (
    .rob_free(rob_free), .iq_free(iq_free), .iew_stall(iew_stall),
    .cmt_stall(cmt_stall), .map_free(map_free), .credit_min(credit_min),
    .resume_ok(resume_ok), .rob_drained(rob_drained)
  );

  rnf_skid #(.DEPTH(SKID_DEPTH), .GW(GRP_W)) u_skid (
    .clk(clk), .rst_n(rst_n), .push(skid_push), .pop(skid_pop),
    .clr(squash_req), .din(in_grp), .dout(skid_head),
    .empty(skid_empty), .count(skid_cnt)
  );

  always_comb begin
    stalled_state = (state_q == ST_BLOCKED) || (state_q == ST_BARRIER) ||
                    (state_q == ST_UNBLOCK);
    working   = !squash_req && ((state_q == ST_IDLE) || (state_q == ST_RUN) ||
                                (state_q == ST_UNBLOCK));
    from_skid = (state_q == ST_UNBLOCK) && !skid_empty;
    src       = from_skid ? skid_head : in_grp;
    walk_off  = from_skid ? off_q : '0;
    walk_size = working ? src[CNT_W-1:0] : '0;
  end

  rnf_slot_walk #(
    .W(W), .CNT_W(CNT_W), .DST_W(DST_W), .TAG_W(TAG_W),
    .PREG_W(PREG_W), .SW(SW), .ALLOC_W(ALLOC_W)
  ) u_walk (
    .grp_size(walk_size), .start_off(walk_off),
    .sq(src[O_SQ +: W]), .ser(src[O_SER +: W]),
    .ndst(src[O_DST +: W*DST_W]), .tag(src[O_TAG +: W*TAG_W]),
    .credit(credit_min), .preg_free(map_free), .drained(rob_drained),
    .n_issue(n_issue), .n_step(n_step), .blk(walk_blk), .ser_blk(walk_ser),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .alloc(map_alloc)
  );

  always_comb begin
    blk_now   = working && walk_blk;
    skid_push = !squash_req && in_nonempty &&
                (stalled_state || (blk_now && !from_skid));
    skid_pop  = working && from_skid && !blk_now;
    dec_stall = stalled_state || blk_now;

    off_d = off_q;
    if (squash_req)   off_d = '0;
    else if (blk_now) off_d = walk_off + n_step;
    else if (working) off_d = '0;

    state_d = state_q;
    if (squash_req) begin
      state_d = ST_SQUASH;
    end else begin
      case (state_q)
        ST_IDLE, ST_RUN: begin
          if (blk_now)          state_d = walk_ser ? ST_BARRIER : ST_BLOCKED;
          else if (in_nonempty) state_d = ST_RUN;
          else                  state_d = ST_IDLE;
        end
        ST_UNBLOCK: begin
          if (blk_now)
            state_d = walk_ser ? ST_BARRIER : ST_BLOCKED;
          else if (skid_empty || ((skid_cnt == SCNT_W'(1)) && !skid_push))
            state_d = ST_RUN;
        end
        ST_BLOCKED: if (resume_ok)                state_d = ST_UNBLOCK;
        ST_BARRIER: if (resume_ok && rob_drained) state_d = ST_UNBLOCK;
        ST_SQUASH:  state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
    end
  end

  assign iss_count   = n_issue;
  assign stage_state = state_q;

  localparam logic signed [SW-1:0] ZERO_S = '0;

  // R2: credit limit as seen at the issue outputs
  p_credit_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_min <= ZERO_S) |-> (iss_count == '0));
  p_credit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_min > ZERO_S) |-> ($signed(SW'(iss_count)) <= credit_min));
  // R5: never allocate more physical registers than reported free
  p_alloc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(map_alloc) <= int'(map_free));
  // R7: blocked states hold decode and issue nothing
  p_hold_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_BLOCKED) || (state_q == ST_BARRIER)) |-> (dec_stall && iss_count == '0));
  // R9: squash empties the skid FIFO and enters Squashing
  p_squash_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash_req |=> (state_q == ST_SQUASH && skid_empty && off_q == '0));
  // R10: a live offset exists only while a group is parked
  p_offset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) || (state_q == ST_RUN)) |-> (off_q == '0));
  // R6: BarrierStall only exits toward Unblocking or Squashing
  p_barrier_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BARRIER) |=> (state_q == ST_BARRIER || state_q == ST_UNBLOCK ||
                                 state_q == ST_SQUASH));
endmodule

// File: tb/rename_flow_ctrl_tb_top.sv
module rename_flow_ctrl_tb_top;
  localparam int W = 4;
  localparam int TAG_W = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  dec_size;
  logic [3:0]  dec_squashed, dec_serial;
  logic [7:0]  dec_ndst;
  logic [31:0] dec_tag;
  logic [4:0]  rob_free, iq_free;
  logic        iew_stall, cmt_stall, squash_req;
  logic [5:0]  map_free;
  logic        dec_stall;
  logic [2:0]  iss_count;
  logic [3:0]  iss_valid;
  logic [31:0] iss_tag;
  logic [3:0]  map_alloc;
  logic [2:0]  stage_state;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rename_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dec_size(dec_size), .dec_squashed(dec_squashed),
    .dec_serial(dec_serial), .dec_ndst(dec_ndst), .dec_tag(dec_tag),
    .rob_free(rob_free), .iq_free(iq_free), .iew_stall(iew_stall),
    .cmt_stall(cmt_stall), .squash_req(squash_req), .map_free(map_free),
    .dec_stall(dec_stall), .iss_count(iss_count), .iss_valid(iss_valid),
    .iss_tag(iss_tag), .map_alloc(map_alloc), .stage_state(stage_state)
  );

  task automatic chk(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic grp(input int size, input int tbase, input logic [3:0] sq,
                     input logic [3:0] ser, input logic [7:0] nd);
    dec_size     = 3'(size);
    dec_squashed = sq;
    dec_serial   = ser;
    dec_ndst     = nd;
    for (int i = 0; i < W; i++) dec_tag[i*TAG_W +: TAG_W] = 8'(tbase + i);
  endtask

  task automatic no_grp();
    grp(0, 0, 4'b0, 4'b0, 8'b0);
  endtask

  function automatic int tag_at(input int pos);
    return int'(iss_tag[pos*TAG_W +: TAG_W]);
  endfunction

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 state", int'(stage_state), 0);
    chk("R1 stall", int'(dec_stall), 0);
    chk("R1 count", int'(iss_count), 0);
  endtask

  task automatic t_full_group();
    @(negedge clk); grp(4, 1, 4'b0, 4'b0, 8'b01010101); #1;
    chk("R2 full count", int'(iss_count), 4);
    chk("R2 tag0", tag_at(0), 1);
    chk("R2 tag3", tag_at(3), 4);
    chk("R5 alloc", int'(map_alloc), 4);
    chk("R2 no stall", int'(dec_stall), 0);
    @(negedge clk); no_grp(); #1;
    chk("R1 running code", int'(stage_state), 1);
    @(negedge clk); #1;
    chk("R1 idle code", int'(stage_state), 0);
  endtask

  task automatic t_squashed_slot();
    @(negedge clk); rob_free = 5'd7; grp(4, 5, 4'b0010, 4'b0, 8'b01010101); #1;
    chk("R4 count", int'(iss_count), 3);
    chk("R4 pos0", tag_at(0), 5);
    chk("R4 pos1", tag_at(1), 7);
    chk("R4 pos2", tag_at(2), 8);
    chk("R4 no stall", int'(dec_stall), 0);
    chk("R4 alloc", int'(map_alloc), 3);
    @(negedge clk); no_grp(); rob_free = 5'd16;
    @(negedge clk);
  endtask

  task automatic t_partial();
    @(negedge clk); rob_free = 5'd6; grp(4, 10, 4'b0, 4'b0, 8'b0); #1;
    chk("R3 partial count", int'(iss_count), 2);
    chk("R3 tag1", tag_at(1), 11);
    chk("R3 stall", int'(dec_stall), 1);
    @(negedge clk); no_grp(); rob_free = 5'd16; iew_stall = 1'b1; #1;
    chk("R3 blocked", int'(stage_state), 2);
    chk("R7 no issue blocked", int'(iss_count), 0);
    @(negedge clk); iew_stall = 1'b0; #1;
    chk("R8 held by iew stall", int'(stage_state), 2);
    @(negedge clk); #1;
    chk("R8 unblocking", int'(stage_state), 3);
    chk("R3 resume count", int'(iss_count), 2);
    chk("R3 resume tag0", tag_at(0), 12);
    chk("R3 resume tag1", tag_at(1), 13);
    @(negedge clk); grp(4, 20, 4'b0, 4'b0, 8'b0); #1;
    chk("R8 running", int'(stage_state), 1);
    chk("R10 count", int'(iss_count), 4);
    chk("R10 starts slot0", tag_at(0), 20);
    @(negedge clk); no_grp();
    @(negedge clk);
  endtask

  task automatic t_zero_credit();
    @(negedge clk); rob_free = 5'd4; grp(4, 30, 4'b0, 4'b0, 8'b0); #1;
    chk("R2 zero credit count", int'(iss_count), 0);
    chk("R2 zero credit stall", int'(dec_stall), 1);
    @(negedge clk); grp(3, 34, 4'b0, 4'b0, 8'b0); #1;
    chk("R2 blocked", int'(stage_state), 2);
    chk("R7 stall", int'(dec_stall), 1);
    @(negedge clk); no_grp(); rob_free = 5'd16; #1;
    chk("R8 still blocked", int'(stage_state), 2);
    @(negedge clk); #1;
    chk("R7 unblock", int'(stage_state), 3);
    chk("R7 first group count", int'(iss_count), 4);
    chk("R7 first group tag", tag_at(0), 30);
    @(negedge clk); #1;
    chk("R7 still unblocking", int'(stage_state), 3);
    chk("R7 second group count", int'(iss_count), 3);
    chk("R7 second group tag", tag_at(0), 34);
    @(negedge clk); #1;
    chk("R8 back to running", int'(stage_state), 1);
    @(negedge clk);
  endtask

  task automatic t_pregs_squash();
    @(negedge clk); map_free = 6'd3; grp(4, 50, 4'b0, 4'b0, 8'b00_01_10_01); #1;
    chk("R5 count", int'(iss_count), 2);
    chk("R5 alloc", int'(map_alloc), 3);
    chk("R5 stall", int'(dec_stall), 1);
    @(negedge clk); no_grp(); map_free = 6'd32; squash_req = 1'b1; #1;
    chk("R5 blocked", int'(stage_state), 2);
    @(negedge clk); squash_req = 1'b0; #1;
    chk("R9 squashing", int'(stage_state), 4);
    chk("R9 no stall", int'(dec_stall), 0);
    @(negedge clk); rob_free = 5'd4; grp(4, 60, 4'b0, 4'b0, 8'b0); #1;
    chk("R9 idle", int'(stage_state), 0);
    chk("R9 zero credit", int'(iss_count), 0);
    @(negedge clk); no_grp(); rob_free = 5'd16; #1;
    chk("R9 blocked", int'(stage_state), 2);
    @(negedge clk); #1;
    chk("R9 unblocking", int'(stage_state), 3);
    chk("R9 no stale group", tag_at(0), 60);
    chk("R9 offset cleared", int'(iss_count), 4);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_serial();
    @(negedge clk); rob_free = 5'd12; grp(4, 70, 4'b0, 4'b0010, 8'b0); #1;
    chk("R6 stops before serial", int'(iss_count), 1);
    chk("R6 stall", int'(dec_stall), 1);
    @(negedge clk); no_grp(); #1;
    chk("R6 barrier", int'(stage_state), 5);
    @(negedge clk); rob_free = 5'd16; #1;
    chk("R6 waits for drain", int'(stage_state), 5);
    @(negedge clk); #1;
    chk("R6 unblocking", int'(stage_state), 3);
    chk("R6 serial first", tag_at(0), 71);
    chk("R6 rest count", int'(iss_count), 3);
    chk("R6 last tag", tag_at(2), 73);
    @(negedge clk); #1;
    chk("R6 running", int'(stage_state), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    no_grp();
    rob_free = 5'd16; iq_free = 5'd16; map_free = 6'd32;
    iew_stall = 1'b0; cmt_stall = 1'b0; squash_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_full_group();
    t_squashed_slot();
    t_partial();
    t_zero_credit();
    t_pregs_squash();
    t_serial();
    finish_run();
  end
endmodule